// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block picks which hardware thread supplies the next instruction to a pipeline that several threads share. It never holds program counters or register state. It only names a thread each cycle and says whether that slot carries an instruction. The caller fetches from the thread named on `issue_tid` whenever `issue_valid` is high.

Two scheduling modes are available, selected per cycle by `mode_sel`. In interleaved mode (`mode_sel` = 0), the thread can change on every clock. Selection rotates round-robin starting just after the last thread that was granted, and any thread whose ready bit is low is skipped. In switch-on-stall mode (`mode_sel` = 1), the block keeps issuing from one thread until that thread raises its long-stall flag. It then asks for a pipeline flush and moves to another ready thread. That thread must refill the pipeline for `REFILL_CYCLES` cycles before any slot is credited to it. Short stalls in this mode only blank the slot and never cause a switch.

Thread numbers are plain binary: thread i is reported as the value i on `issue_tid`, and bit i of each per-thread vector belongs to thread i. There is no back-pressure. Every cycle is one issue slot, and the consumer takes it or it is lost.

Top module: `thread_issue_sel`

## Requirements
- R1: While reset is held and with no thread ready, `issue_valid` and `flush_req` are 0. After reset releases, the first interleaved grant goes to thread 0 and the stall-mode refill window is empty.
- R2: In interleaved mode with every thread ready, consecutive cycles grant threads 0, 1, 2, 3, 0 in that order.
- R3: In interleaved mode, a thread with its `thread_ready` bit low is never granted. Whenever `issue_valid` is 1, the named thread is ready.
- R4: The interleaved search starts at the thread after the last granted one. After granting thread 2 with threads 0, 1 and 3 ready, the next grant is thread 3.
- R5: When no thread is ready, `issue_valid` is 0 and the last-granted pointer does not move.
- R6: In interleaved mode, `long_stall` has no effect and `flush_req` stays 0.
- R7: In switch-on-stall mode, the current thread keeps every slot while it raises no long stall, even if other threads are ready.
- R8: A short stall in switch-on-stall mode (current thread not ready, no long stall) gives `issue_valid` = 0 with no switch and no flush.
- R9: A long stall on the current thread in switch-on-stall mode, with another thread ready, raises `flush_req` for exactly one cycle with `issue_valid` = 0. The next thread is the first ready one after the stalled thread in rotating order, skipping the stalled thread.
- R10: After a flush, `issue_valid` stays 0 for `REFILL_CYCLES` cycles while `issue_tid` already names the new thread. Issue then resumes from that thread.
- R11: A long stall with no other thread ready gives no flush and no switch. The slot is idle.
- R12: A long stall raised during the refill window is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | 0 = interleave every cycle, 1 = switch on long stall |
| thread_ready | input | NUM_THREADS | Bit i high when thread i can issue |
| long_stall | input | NUM_THREADS | Bit i high when thread i has hit a costly stall |
| issue_valid | output | 1 | The current slot carries an instruction of `issue_tid` |
| issue_tid | output | TID_W | Binary number of the selected thread |
| flush_req | output | 1 | Empty the pipeline for a thread switch |

## Verification
The bench builds the block with four threads and a refill window of three cycles. Three cycles differs from the default, so a window length hard-wired to the default would be caught. Four threads make a full rotation short enough to walk in a few vectors. They also make the wrap from thread 3 back to thread 0 reachable both in interleaved grants and in the stall-mode successor search. The stall-mode sequences reach a switch, the whole refill window, a long stall raised inside that window, and a long stall with no other thread ready.

// File: rtl/thr_sel_pkg.sv
package thr_sel_pkg;
  typedef enum logic {
    SEL_INTERLEAVE = 1'b0,
    SEL_ON_STALL   = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/rr_pick.sv
// Rotating first-set search: starting one past base, wrapping around.
module rr_pick #(
  parameter int N    = 4,
  localparam int TW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [TW-1:0] base,
  output logic          found,
  output logic [TW-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = base;
    for (int k = 1; k <= N; k++) begin
      int slot;
      slot = int'(base) + k;
      if (slot >= N) slot = slot - N;
      if (!found && req[slot]) begin
        found = 1'b1;
        pick  = TW'(slot);
      end
    end
  end

  always_comb begin
    if (found) assert_pick_requested_R3: assert (req[pick]);
  end
endmodule

// File: rtl/refill_timer.sv
// Counts the blank slots a freshly switched-in thread spends refilling.
module refill_timer #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (load)   cnt <= CW'(DEPTH);
    else if (busy)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_load_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel
  import thr_sel_pkg::*;
#(
  parameter int NUM_THREADS   = 4,
  parameter int REFILL_CYCLES = 4,
  localparam int TID_W        = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_sel,
  input  logic [NUM_THREADS-1:0] thread_ready,
  input  logic [NUM_THREADS-1:0] long_stall,
  output logic                   issue_valid,
  output logic [TID_W-1:0]       issue_tid,
  output logic                   flush_req
);
  sel_mode_e              mode;
  logic [TID_W-1:0]       cur_tid, nxt_tid;
  logic [NUM_THREADS-1:0] cur_onehot, others_ready;
  logic                   rr_found, sw_found, refilling, start_refill;
  logic [TID_W-1:0]       rr_tid, sw_tid;

  assign mode = sel_mode_e'(mode_sel);

  generate
    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_mask
      assign cur_onehot[g] = (cur_tid == TID_W'(g));
    end
  endgenerate
  assign others_ready = thread_ready & ~cur_onehot;

  // Interleaved grant: any ready thread, the last granted one coming last.
  rr_pick #(.N(NUM_THREADS)) u_rr (
    .req(thread_ready), .base(cur_tid), .found(rr_found), .pick(rr_tid));

  // Successor after a costly stall: never the stalled thread itself.
  rr_pick #(.N(NUM_THREADS)) u_sw (
    .req(others_ready), .base(cur_tid), .found(sw_found), .pick(sw_tid));

  refill_timer #(.DEPTH(REFILL_CYCLES)) u_refill (
    .clk(clk), .rst_n(rst_n), .clear(mode == SEL_INTERLEAVE),
    .load(start_refill), .busy(refilling));

  always_comb begin
    issue_valid  = 1'b0;
    issue_tid    = cur_tid;
    flush_req    = 1'b0;
    start_refill = 1'b0;
    nxt_tid      = cur_tid;
    if (mode == SEL_INTERLEAVE) begin
      issue_valid = rr_found;
      if (rr_found) begin
        issue_tid = rr_tid;
        nxt_tid   = rr_tid;
      end
    end else if (refilling) begin
      issue_valid = 1'b0;
    end else if (long_stall[cur_tid]) begin
      if (sw_found) begin
        flush_req    = 1'b1;
        start_refill = 1'b1;
        nxt_tid      = sw_tid;
      end
    end else begin
      issue_valid = thread_ready[cur_tid];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_tid <= TID_W'(NUM_THREADS - 1);
    else        cur_tid <= nxt_tid;
  end

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_idle_none_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|thread_ready) |-> !issue_valid);
  assert_grant_is_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> thread_ready[issue_tid]);
  assert_no_flush_interleave_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SEL_INTERLEAVE) |-> !flush_req);
  assert_switch_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> (!issue_valid && thread_ready[sw_tid] && sw_tid != issue_tid));
  assert_refill_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req ##1 (mode == SEL_ON_STALL) |-> (!issue_valid && !flush_req));
  assert_hold_thread_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mode == SEL_ON_STALL && $past(mode == SEL_ON_STALL) && !$past(flush_req))
      |-> $stable(issue_tid));
endmodule

// File: tb/thread_issue_sel_test.sv
module thread_issue_sel_test;
  localparam int NT  = 4;
  localparam int RF  = 3;
  localparam int TW  = 2;
  localparam int NV  = 29;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_sel = 1'b0;
  logic [NT-1:0] thread_ready = '0;
  logic [NT-1:0] long_stall = '0;
  logic          issue_valid, flush_req;
  logic [TW-1:0] issue_tid;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  thread_issue_sel #(.NUM_THREADS(NT), .REFILL_CYCLES(RF)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .thread_ready(thread_ready), .long_stall(long_stall),
    .issue_valid(issue_valid), .issue_tid(issue_tid), .flush_req(flush_req));

  // {mode, ready[3:0], long_stall[3:0], exp_valid, exp_tid[1:0], exp_flush}
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 4'b1111, 4'b0000, 1'b1, 2'd0, 1'b0},  // 0  R1
    {1'b0, 4'b1111, 4'b0000, 1'b1, 2'd1, 1'b0},  // 1  R2
    {1'b0, 4'b1111, 4'b0000, 1'b1, 2'd2, 1'b0},  // 2  R2
    {1'b0, 4'b1111, 4'b0000, 1'b1, 2'd3, 1'b0},  // 3  R2
    {1'b0, 4'b1111, 4'b0000, 1'b1, 2'd0, 1'b0},  // 4  R2 wrap
    {1'b0, 4'b1010, 4'b0000, 1'b1, 2'd1, 1'b0},  // 5  R3
    {1'b0, 4'b1010, 4'b0000, 1'b1, 2'd3, 1'b0},  // 6  R3
    {1'b0, 4'b1010, 4'b0000, 1'b1, 2'd1, 1'b0},  // 7  R3
    {1'b0, 4'b0000, 4'b0000, 1'b0, 2'd1, 1'b0},  // 8  R5 idle
    {1'b0, 4'b1111, 4'b0000, 1'b1, 2'd2, 1'b0},  // 9  R5 pointer held
    {1'b0, 4'b1011, 4'b0000, 1'b1, 2'd3, 1'b0},  // 10 R4
    {1'b0, 4'b1111, 4'b1111, 1'b1, 2'd0, 1'b0},  // 11 R6
    {1'b0, 4'b0001, 4'b0000, 1'b1, 2'd0, 1'b0},  // 12 R3 lone thread
    {1'b1, 4'b1111, 4'b0000, 1'b1, 2'd0, 1'b0},  // 13 R7
    {1'b1, 4'b1111, 4'b0000, 1'b1, 2'd0, 1'b0},  // 14 R7
    {1'b1, 4'b1110, 4'b0000, 1'b0, 2'd0, 1'b0},  // 15 R8
    {1'b1, 4'b1111, 4'b0000, 1'b1, 2'd0, 1'b0},  // 16 R8
    {1'b1, 4'b1010, 4'b0001, 1'b0, 2'd0, 1'b1},  // 17 R9
    {1'b1, 4'b1111, 4'b0010, 1'b0, 2'd1, 1'b0},  // 18 R12
    {1'b1, 4'b1111, 4'b0000, 1'b0, 2'd1, 1'b0},  // 19 R10
    {1'b1, 4'b1111, 4'b0000, 1'b0, 2'd1, 1'b0},  // 20 R10
    {1'b1, 4'b1111, 4'b0000, 1'b1, 2'd1, 1'b0},  // 21 R10
    {1'b1, 4'b0010, 4'b0010, 1'b0, 2'd1, 1'b0},  // 22 R11
    {1'b1, 4'b0110, 4'b0000, 1'b1, 2'd1, 1'b0},  // 23 R11
    {1'b1, 4'b0001, 4'b0010, 1'b0, 2'd1, 1'b1},  // 24 R9 wrap
    {1'b1, 4'b1111, 4'b0000, 1'b0, 2'd0, 1'b0},  // 25 R10
    {1'b1, 4'b1111, 4'b0000, 1'b0, 2'd0, 1'b0},  // 26 R10
    {1'b1, 4'b1111, 4'b0000, 1'b0, 2'd0, 1'b0},  // 27 R10
    {1'b1, 4'b1111, 4'b0000, 1'b1, 2'd0, 1'b0}   // 28 R10
  };

  function automatic string req_of(int row);
    case (row)
      0:                      return "R1";
      1, 2, 3, 4:             return "R2";
      5, 6, 7, 12:            return "R3";
      8, 9:                   return "R5";
      10:                     return "R4";
      11:                     return "R6";
      13, 14:                 return "R7";
      15, 16:                 return "R8";
      17, 24:                 return "R9";
      18:                     return "R12";
      22, 23:                 return "R11";
      default:                return "R10";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic apply(logic m, logic [NT-1:0] rdy, logic [NT-1:0] ls);
    @(negedge clk);
    mode_sel     = m;
    thread_ready = rdy;
    long_stall   = ls;
    #1;
  endtask

  initial begin
    // Reset state (R1)
    repeat (2) @(negedge clk);
    #1;
    check("R1", "valid in reset", int'(issue_valid), 0);
    check("R1", "flush in reset", int'(flush_req), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      v = VEC[i];
      apply(v[12], v[11:8], v[7:4]);
      check(req_of(i), $sformatf("row %0d valid", i), int'(issue_valid), int'(v[3]));
      check(req_of(i), $sformatf("row %0d tid", i),   int'(issue_tid),   int'(v[2:1]));
      check(req_of(i), $sformatf("row %0d flush", i), int'(flush_req),   int'(v[0]));
    end

    // Reset in the middle of a refill window (R1)
    apply(1'b1, 4'b1111, 4'b0001);
    check("R9", "flush before reset", int'(flush_req), 1);
    @(negedge clk);
    rst_n        = 1'b0;
    thread_ready = '0;
    long_stall   = '0;
    #1;
    check("R1", "valid mid reset", int'(issue_valid), 0);
    check("R1", "flush mid reset", int'(flush_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b0, 4'b1111, 4'b0000);
    check("R1", "first grant valid", int'(issue_valid), 1);
    check("R1", "first grant tid", int'(issue_tid), 0);
    apply(1'b1, 4'b1111, 4'b0000);
    check("R1", "no refill after reset", int'(issue_valid), 1);
    check("R1", "stall-mode tid after reset", int'(issue_tid), 0);

    finish_run();
  end

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule